// File: doc/BRIEF.md
# NAND Flash Host Bus Sequencer

This block sits between a processor register port and the pins of an 8-bit NAND flash device. Software writes a command byte, an address byte, a data byte or a read request into dedicated registers. Each write becomes a tagged entry in a small write queue. A pin sequencer drains the queue in order and turns each entry into one flash bus cycle. Command and address cycles qualify the write strobe with the command latch or address latch line. Data writes drive the I/O bus under a write strobe. A read request produces one read strobe and captures the byte the device returns.

The lengths of the write and read strobes are programmed in a control register. Status bits show the state of the queue, the pending page transfers and the synchronised ready/busy line. Interrupt flags latch events until software clears them by writing ones. A masked OR of those flags drives a single interrupt output. A read is issued with a write of any value to the read-request register. Software then waits for the read-ready flag, fetches the byte from the read-data register, and clears the flag.

Register map (4-bit word address): 0 control, 1 status, 2 interrupt flags, 3 interrupt mask, 4 command, 5 address, 6 write data, 7 read request, 8 read data. Any other address reads as zero.

Top module: `nand_host_seq`

## Requirements
- R1: After reset the control, mask and flag registers read 0. Status reads 0x11 while the ready/busy pin is high. Both strobes are high, both latch lines are low, and the interrupt output is 0.
- R2: The control register holds 10 bits and reads back as written, with bits 15:10 reading 0. Bits [3:0] set the write-strobe delay, bits [7:4] set the read-strobe delay, bit 8 is the width select and bit 9 is the 512-byte page select.
- R3: A write to the command register produces one write-strobe low pulse. During the pulse the command latch is high, the address latch is low and the written byte is driven on the I/O bus with output enable high.
- R4: A write to the address register produces one write-strobe low pulse. During the pulse the address latch is high, the command latch is low and the written byte is driven.
- R5: A write to the write-data register produces one write-strobe low pulse with both latch lines low and the byte driven.
- R6: A write of any value to the read-request register produces one read-strobe low pulse with the I/O output enable low. The byte on the input pins is captured into the read-data register, and interrupt flag bit 3 (read ready) is set.
- R7: A write-strobe pulse lasts (write delay + 1) cycles and a read-strobe pulse lasts (read delay + 1) cycles. Queued cycles are separated by exactly one cycle with both strobes high, and the strobes are never low together.
- R8: The queue holds 4 entries and they leave in write order. Status bit 1 shows the queue is full. A queue write while the queue is full is dropped, issues no bus cycle, and sets interrupt flag bit 1.
- R9: Status bit 0 follows the synchronised ready/busy pin. Bit 2 is set while write-data entries are queued or in flight. Bit 3 is set while read requests are queued or in flight. Bit 4 is set when the queue is empty.
- R10: Interrupt flags are sticky and are cleared only by writing 1 to them. Bit 2 sets when the queue goes from non-empty to empty. Bit 4 sets when the last pending write-data cycle completes.
- R11: Interrupt flag bit 0 sets on a rising edge of the synchronised ready/busy pin.
- R12: The interrupt output is high exactly when a flag bit and the matching mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| irq_o | output | 1 | Masked interrupt request |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | I/O bus output byte |
| nf_io_oe | output | 1 | I/O bus output enable |
| nf_io_in | input | 8 | I/O bus input byte |
| nf_rb | input | 1 | Ready/busy pin, high when ready |

## Verification
A corrupted queue pointer or count shows up at the pins when the next strobe carries the wrong byte or the wrong latch line. It also shows up as a missing or extra pulse, a wrong full flag, or an overflow that was not expected. A wrong strobe counter gives a pulse of the wrong length, or a gap between queued cycles that is not one cycle. Either fault is visible within one bus cycle (at most 17 clocks) of the entry being popped. A wrong pending count leaves status bits 2 and 3 set after the queue drains, or fires the write-done flag early. That is visible at the first status read after the last data cycle.

// File: rtl/nfh_pkg.sv
`timescale 1ns/1ps
package nfh_pkg;

    localparam int DLY_W = 4;

    // register word addresses
    localparam logic [3:0] RA_CTRL  = 4'd0;
    localparam logic [3:0] RA_STAT  = 4'd1;
    localparam logic [3:0] RA_IFLAG = 4'd2;
    localparam logic [3:0] RA_IMASK = 4'd3;
    localparam logic [3:0] RA_CMD   = 4'd4;
    localparam logic [3:0] RA_ADDR  = 4'd5;
    localparam logic [3:0] RA_WDATA = 4'd6;
    localparam logic [3:0] RA_RREQ  = 4'd7;
    localparam logic [3:0] RA_RDATA = 4'd8;

    // interrupt flag bit positions
    localparam int IB_READY = 0;
    localparam int IB_OVF   = 1;
    localparam int IB_DRAIN = 2;
    localparam int IB_RDRDY = 3;
    localparam int IB_WDONE = 4;
    localparam int N_IRQ    = 5;

    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_ADDR  = 2'd1,
        OP_WDATA = 2'd2,
        OP_RREQ  = 2'd3
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [7:0] data;
    } wb_entry_t;

    typedef struct packed {
        logic             page512;
        logic             wide;
        logic [DLY_W-1:0] rd_dly;
        logic [DLY_W-1:0] wr_dly;
    } ctl_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_STRB  = 2'd1,
        SQ_RECOV = 2'd2
    } seq_st_e;

    function automatic logic [DLY_W-1:0] strobe_dly(op_e op, ctl_t c);
        return (op == OP_RREQ) ? c.rd_dly : c.wr_dly;
    endfunction

endpackage

// File: rtl/nfh_wbuf.sv
`timescale 1ns/1ps
module nfh_wbuf
    import nfh_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  wb_entry_t push_ent,
    input  logic      pop,
    output wb_entry_t head,
    output logic      full,
    output logic      empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    wb_entry_t     mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/nfh_busseq.sv
`timescale 1ns/1ps
module nfh_busseq
    import nfh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctl_t       ctl,
    input  logic       ent_valid,
    input  wb_entry_t  ent,
    output logic       pop,
    input  logic [7:0] io_in,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       done,
    output op_e        done_op,
    output logic [7:0] rd_byte
);
    seq_st_e          st;
    wb_entry_t        cur;
    logic [DLY_W-1:0] cnt;
    logic             active, strobing, is_rd;

    assign pop      = ent_valid && (st != SQ_STRB);
    assign active   = (st != SQ_IDLE);
    assign strobing = (st == SQ_STRB);
    assign is_rd    = (cur.op == OP_RREQ);
    assign done     = strobing && (cnt == '0);
    assign done_op  = cur.op;

    assign cle    = active && (cur.op == OP_CMD);
    assign ale    = active && (cur.op == OP_ADDR);
    assign we_n   = !(strobing && !is_rd);
    assign re_n   = !(strobing && is_rd);
    assign io_oe  = active && !is_rd;
    assign io_out = cur.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            cur     <= '{op: OP_CMD, data: 8'h00};
            cnt     <= '0;
            rd_byte <= '0;
        end else begin
            case (st)
                SQ_STRB: begin
                    if (cnt == '0) begin
                        st <= SQ_RECOV;
                        if (is_rd) rd_byte <= io_in;
                    end else begin
                        cnt <= cnt - DLY_W'(1);
                    end
                end
                default: begin
                    if (pop) begin
                        cur <= ent;
                        cnt <= strobe_dly(ent.op, ctl);
                        st  <= SQ_STRB;
                    end else begin
                        st <= SQ_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/nfh_rbsync.sv
`timescale 1ns/1ps
module nfh_rbsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] sh;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= {sh[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= sh[STAGES-1];
    end

    assign level = sh[STAGES-1];
    assign rise  = sh[STAGES-1] && !prev;
endmodule

// File: rtl/nand_host_seq.sv
`timescale 1ns/1ps
module nand_host_seq
    import nfh_pkg::*;
#(
    parameter int WB_DEPTH    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq_o,
    output logic        nf_cle,
    output logic        nf_ale,
    output logic        nf_we_n,
    output logic        nf_re_n,
    output logic [7:0]  nf_io_out,
    output logic        nf_io_oe,
    input  logic [7:0]  nf_io_in,
    input  logic        nf_rb
);
    localparam int PCW = $clog2(WB_DEPTH + 2);

    ctl_t             ctl_q;
    logic [N_IRQ-1:0] irq_q, mask_q, irq_set, irq_clr;
    logic [PCW-1:0]   wpend_q, rpend_q;
    logic             q_req, q_ok, wb_full, wb_empty, wb_empty_q, wb_pop;
    wb_entry_t        q_ent, wb_head;
    logic             seq_done;
    op_e              seq_done_op;
    logic [7:0]       rd_byte;
    logic             rb_level, rb_rise;
    logic             wr_in, wr_out, rd_in, rd_out;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[15:10];

    // queue-write decode
    always_comb begin
        q_req = reg_we;
        q_ent = '{op: OP_CMD, data: reg_wdata[7:0]};
        case (reg_addr)
            RA_CMD:   q_ent.op = OP_CMD;
            RA_ADDR:  q_ent.op = OP_ADDR;
            RA_WDATA: q_ent.op = OP_WDATA;
            RA_RREQ:  q_ent.op = OP_RREQ;
            default:  q_req = 1'b0;
        endcase
    end
    assign q_ok = q_req && !wb_full;

    nfh_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
        .clk(clk), .rst(rst),
        .push(q_req), .push_ent(q_ent),
        .pop(wb_pop), .head(wb_head),
        .full(wb_full), .empty(wb_empty)
    );

    nfh_busseq u_seq (
        .clk(clk), .rst(rst), .ctl(ctl_q),
        .ent_valid(!wb_empty), .ent(wb_head), .pop(wb_pop),
        .io_in(nf_io_in),
        .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n), .re_n(nf_re_n),
        .io_out(nf_io_out), .io_oe(nf_io_oe),
        .done(seq_done), .done_op(seq_done_op), .rd_byte(rd_byte)
    );

    nfh_rbsync #(.STAGES(SYNC_STAGES)) u_rb (
        .clk(clk), .rst(rst), .pin(nf_rb),
        .level(rb_level), .rise(rb_rise)
    );

    // pending-transfer accounting
    assign wr_in  = q_ok && (q_ent.op == OP_WDATA);
    assign wr_out = seq_done && (seq_done_op == OP_WDATA);
    assign rd_in  = q_ok && (q_ent.op == OP_RREQ);
    assign rd_out = seq_done && (seq_done_op == OP_RREQ);

    always_comb begin
        irq_set           = '0;
        irq_set[IB_READY] = rb_rise;
        irq_set[IB_OVF]   = q_req && wb_full;
        irq_set[IB_DRAIN] = wb_empty && !wb_empty_q;
        irq_set[IB_RDRDY] = rd_out;
        irq_set[IB_WDONE] = wr_out && !wr_in && (wpend_q == PCW'(1));
        irq_clr = (reg_we && reg_addr == RA_IFLAG) ? reg_wdata[N_IRQ-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= '0;
            mask_q     <= '0;
            irq_q      <= '0;
            wpend_q    <= '0;
            rpend_q    <= '0;
            wb_empty_q <= 1'b1;
        end else begin
            if (reg_we && reg_addr == RA_CTRL)  ctl_q  <= ctl_t'(reg_wdata[9:0]);
            if (reg_we && reg_addr == RA_IMASK) mask_q <= reg_wdata[N_IRQ-1:0];
            irq_q      <= (irq_q & ~irq_clr) | irq_set;
            wb_empty_q <= wb_empty;
            case ({wr_in, wr_out})
                2'b10:   wpend_q <= wpend_q + PCW'(1);
                2'b01:   wpend_q <= wpend_q - PCW'(1);
                default: wpend_q <= wpend_q;
            endcase
            case ({rd_in, rd_out})
                2'b10:   rpend_q <= rpend_q + PCW'(1);
                2'b01:   rpend_q <= rpend_q - PCW'(1);
                default: rpend_q <= rpend_q;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = {6'b0, ctl_q};
            RA_STAT:  reg_rdata = {11'b0, wb_empty, (rpend_q != '0),
                                   (wpend_q != '0), wb_full, rb_level};
            RA_IFLAG: reg_rdata = {11'b0, irq_q};
            RA_IMASK: reg_rdata = {11'b0, mask_q};
            RA_RDATA: reg_rdata = {8'b0, rd_byte};
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_o = |(irq_q & mask_q);
endmodule

// File: rtl/nand_host_seq_chk.sv
`timescale 1ns/1ps
module nand_host_seq_chk
    import nfh_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [3:0]       reg_addr,
    input logic             nf_cle,
    input logic             nf_ale,
    input logic             nf_we_n,
    input logic             nf_re_n,
    input logic             nf_io_oe,
    input logic             wb_full,
    input logic [N_IRQ-1:0] irq_q,
    input logic             seq_done,
    input op_e              seq_done_op
);
    logic queue_wr;
    assign queue_wr = reg_we && (reg_addr >= RA_CMD) && (reg_addr <= RA_RREQ);

    p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        !(!nf_we_n && !nf_re_n));

    p_recovery_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(nf_we_n) || $rose(nf_re_n)) |-> (nf_we_n && nf_re_n));

    p_latch_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(nf_cle && nf_ale));

    p_read_nodrive_r6: assert property (@(posedge clk) disable iff (rst)
        !nf_re_n |-> !nf_io_oe);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (queue_wr && wb_full) |=> irq_q[IB_OVF]);

    p_read_ready_r6: assert property (@(posedge clk) disable iff (rst)
        (seq_done && seq_done_op == OP_RREQ) |=> irq_q[IB_RDRDY]);
endmodule

bind nand_host_seq nand_host_seq_chk u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_io_oe(nf_io_oe), .wb_full(wb_full), .irq_q(irq_q),
    .seq_done(seq_done), .seq_done_op(seq_done_op)
);

// File: tb/nand_host_seq_tb.sv
`timescale 1ns/1ps
module nand_host_seq_tb;
    localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_FLAG = 4'd2, A_MASK = 4'd3;
    localparam logic [3:0] A_CMD = 4'd4, A_ADR = 4'd5, A_WD = 4'd6, A_RQ = 4'd7, A_RD = 4'd8;

    // {ctl[7:0], register address[3:0], byte[7:0]}
    localparam logic [19:0] VECS [8] = '{
        {8'h00, 4'd4, 8'h70}, {8'h03, 4'd5, 8'h12},
        {8'h25, 4'd6, 8'hA5}, {8'h50, 4'd7, 8'h3C},
        {8'h0F, 4'd4, 8'hFF}, {8'hF0, 4'd7, 8'hC3},
        {8'h71, 4'd6, 8'h00}, {8'h00, 4'd7, 8'h5A}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq_o, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
    logic [7:0]  nf_io_out;
    logic [7:0]  nf_io_in = 8'h00;
    logic        nf_rb = 1'b1;

    int n_vec = 0;
    int n_bad = 0;

    nand_host_seq u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in),
        .nf_rb(nf_rb)
    );

    always #4 clk = ~clk;

    // pin monitor: one log entry per strobe pulse
    int         lg_n = 0;
    int         lg_w [64];
    int         lg_gap [64];
    logic       lg_rd [64];
    logic       lg_cle [64];
    logic       lg_ale [64];
    logic       lg_oe [64];
    logic [7:0] lg_d [64];
    int         lo_cnt = 0;
    int         hi_cnt = 0;
    int         cur_gap = 0;
    logic       c_rd, c_cle, c_ale, c_oe;
    logic [7:0] c_d;

    always @(negedge clk) begin
        if (rst) begin
            lo_cnt = 0;
            hi_cnt = 0;
        end else if (!nf_we_n || !nf_re_n) begin
            if (lo_cnt == 0) cur_gap = hi_cnt;
            lo_cnt++;
            c_rd = !nf_re_n; c_cle = nf_cle; c_ale = nf_ale; c_oe = nf_io_oe; c_d = nf_io_out;
        end else if (lo_cnt > 0) begin
            if (lg_n < 64) begin
                lg_w[lg_n] = lo_cnt; lg_gap[lg_n] = cur_gap; lg_rd[lg_n] = c_rd;
                lg_cle[lg_n] = c_cle; lg_ale[lg_n] = c_ale; lg_oe[lg_n] = c_oe; lg_d[lg_n] = c_d;
                lg_n++;
            end
            lo_cnt = 0;
            hi_cnt = 1;
        end else begin
            hi_cnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int k = 0; k < 200; k++) begin
            rd(A_STAT, s);
            if (s[4]) break;
        end
        repeat (24) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    logic [15:0] r;
    logic [19:0] v;
    int          base, expw;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset state
        rd(A_CTRL, r); check("R1 ctrl", r, 0);
        rd(A_STAT, r); check("R1 status", r, 16'h11);
        rd(A_FLAG, r); check("R1 flags", r, 0);
        rd(A_MASK, r); check("R1 mask", r, 0);
        check("R1 pins", {nf_we_n, nf_re_n, nf_cle, nf_ale, irq_o}, 5'b11000);

        // R2 control readback
        wr(A_CTRL, 16'h03A5); rd(A_CTRL, r); check("R2 ctrl readback", r, 16'h03A5);
        wr(A_CTRL, 16'hFFFF); rd(A_CTRL, r); check("R2 ctrl upper bits", r, 16'h03FF);

        // table of single bus cycles: R3 R4 R5 R6 R7
        for (int i = 0; i < 8; i++) begin
            v = VECS[i];
            wr(A_CTRL, {8'h00, v[19:12]});
            nf_io_in = v[7:0];
            base = lg_n;
            wr(v[11:8], {8'h00, v[7:0]});
            wait_idle();
            expw = (v[11:8] == A_RQ) ? int'(v[19:16]) + 1 : int'(v[15:12]) + 1;
            check("R7 one pulse per entry", lg_n - base, 1);
            check("R7 strobe width", lg_w[base], expw);
            check("R3 R4 latch lines", {lg_cle[base], lg_ale[base]},
                  {(v[11:8] == A_CMD), (v[11:8] == A_ADR)});
            if (v[11:8] == A_RQ) begin
                check("R6 read strobe used", lg_rd[base], 1);
                check("R6 bus not driven", lg_oe[base], 0);
                rd(A_RD, r); check("R6 captured byte", r, v[7:0]);
                rd(A_FLAG, r); check("R6 read ready flag", r[3], 1);
                wr(A_FLAG, 16'h0008);
                rd(A_FLAG, r); check("R10 read ready cleared", r[3], 0);
            end else begin
                check("R5 write strobe used", lg_rd[base], 0);
                check("R5 bus driven", lg_oe[base], 1);
                check("R5 byte on bus", lg_d[base], v[7:0]);
            end
        end

        // R8 overflow: six back-to-back data writes with long strobes
        wr(A_FLAG, 16'h001F);
        wr(A_CTRL, 16'h00FF);
        base = lg_n;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            reg_we = 1'b1; reg_addr = A_WD; reg_wdata = 16'(k);
        end
        @(negedge clk);
        reg_we = 1'b0;
        rd(A_STAT, r); check("R8 full flag", r[1], 1);
        check("R9 write pending", r[2], 1);
        rd(A_FLAG, r); check("R8 overflow flag", r[1], 1);
        wr(A_FLAG, 16'h0002);
        rd(A_FLAG, r); check("R10 overflow cleared", r[1], 0);
        wait_idle();
        check("R8 dropped write issues no cycle", lg_n - base, 5);
        for (int k = 0; k < 5; k++) begin
            check("R8 queue order", lg_d[base + k], k);
            check("R7 long width", lg_w[base + k], 16);
        end
        for (int k = 1; k < 5; k++) check("R7 recovery gap", lg_gap[base + k], 1);
        rd(A_STAT, r); check("R9 drained status", r, 16'h11);
        rd(A_FLAG, r); check("R10 drain and write-done flags", r & 16'h14, 16'h14);

        // R10 sticky: clear only write-done
        wr(A_FLAG, 16'h0010);
        rd(A_FLAG, r); check("R10 selective clear", r & 16'h14, 16'h04);
        wr(A_FLAG, 16'h001F);
        rd(A_FLAG, r); check("R10 all cleared", r, 0);

        // R9 read pending
        wr(A_RQ, 16'h0000);
        rd(A_STAT, r); check("R9 read pending", r[3], 1);
        wait_idle();
        rd(A_STAT, r); check("R9 read pending clear", r[3], 0);
        wr(A_FLAG, 16'h001F);

        // R11 ready/busy edge, R12 masking
        nf_rb = 1'b0;
        repeat (5) @(negedge clk);
        rd(A_STAT, r); check("R9 busy seen", r[0], 0);
        rd(A_FLAG, r); check("R11 no flag on fall", r[0], 0);
        nf_rb = 1'b1;
        repeat (5) @(negedge clk);
        rd(A_STAT, r); check("R9 ready seen", r[0], 1);
        rd(A_FLAG, r); check("R11 flag on rise", r[0], 1);
        #1 check("R12 masked off", irq_o, 0);
        wr(A_MASK, 16'h0001);
        #1 check("R12 masked on", irq_o, 1);
        wr(A_FLAG, 16'h0001);
        #1 check("R12 cleared", irq_o, 0);

        finish_run();
    end
endmodule